// File: doc/BRIEF.md
# SPI Frame Shift Engine

This block is the bit-level core of a master-mode SPI port. It sends and receives one frame per request. A requester offers a frame through a valid/ready handshake. The frame carries a 32-bit attribute word, a transmit word, a one-hot chip-select pattern and a flag that keeps the select asserted. The engine then asserts the select and waits a programmable settle time. It toggles SCK with the chosen polarity and phase and shifts the frame out and in, in either bit order. After a second programmable hold time it returns the received word with a one-cycle done strobe. A third programmable gap must pass before the next frame is taken.

Back-pressure is one-sided. `frm_ready` is high only while the engine is idle. A request offered while the engine is busy must be held, with all of its fields unchanged, until a clock edge where valid and ready are both high. The engine samples the attribute, data, select and continue inputs only at that edge. The result side is a plain strobe. A frame cannot be paused once it has started, so `rx_word` holds its value until the next `frm_done`.

Top module: `spi_frame_engine`

## Requirements
- R1: SCK half period in clocks equals P*S/2. P is {2,3,5,7} selected by attribute bits [17:16]. S is chosen by bits [3:0]: codes 0..3 give 2,4,6,8 and code k of 4 or more gives 2^k.
- R2: Three delays each last p*2^(s+1) clocks, with p one of {1,3,5,7}. Select-to-first-edge takes p from [23:22] and s from [15:12]. Last-edge-to-done takes p from [21:20] and s from [11:8]. The gap before the next acceptance takes p from [19:18] and s from [7:4].
- R3: SCK rests at the polarity bit [26] outside the shifting phase. It makes exactly two toggles per data bit.
- R4: Bit [24] set sends bit 0 first, clear sends bit W-1 first. The first bit is on MOSI from the cycle after acceptance. With phase bit [25] clear, MOSI changes on even edges. With [25] set, it changes on odd edges from the third onward. MOSI holds the last bit after the frame.
- R5: MISO is captured on odd SCK edges when [25] is clear and on even edges when it is set. It is stored in the same bit order. The result is right-aligned and bits at or above W are zero.
- R6: Frame width W is bits [30:27] plus one. Codes 0..2 are treated as 4 bits. Transmit bits at or above W never reach MOSI.
- R7: `cs_n` idles all high. From the cycle after acceptance it drives the inverse of the request's one-hot select. It releases to all high together with `frm_done` unless the continue flag was set, in which case it stays asserted.
- R8: `frm_done` is a one-cycle pulse in the first cycle after the last-edge delay. `rx_word` changes only in that cycle.
- R9: `frm_ready` is high only when idle (from the end of the gap until acceptance). Inputs offered while ready is low, or while valid is low, have no effect on any output.
- R10: After reset: SCK 0, MOSI 0, `cs_n` all high, `rx_word` 0, `frm_done` 0, `frm_ready` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr | input | 32 | Frame attribute word (timing, width, mode) |
| frm_valid | input | 1 | Request offered |
| frm_ready | output | 1 | Engine idle, request taken on this edge if valid |
| frm_tx | input | DW | Transmit word, right-aligned |
| frm_cs | input | NCS | One-hot chip-select pattern |
| frm_cont | input | 1 | Keep select asserted after this frame |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | NCS | Active-low chip selects |
| rx_word | output | DW | Last received word, right-aligned |
| frm_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
A wrong delay or period count shows up first on SCK: its first toggle moves off the expected cycle, and that can be seen within one half period. A wrong edge counter or phase decode shows on MOSI at the very next shift edge. It also corrupts `rx_word`, but that only becomes visible at `frm_done`, up to a full frame later. A state error that leaves the engine busy holds `frm_ready` low past the expected gap end, and every later frame then slips.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int FE_CNT_W = 20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL, ST_GAP
  } fe_state_e;

  // half SCK period in clocks: prime prescaler times half the scaler
  function automatic logic [FE_CNT_W-1:0] fe_half_period(input logic [1:0] pre,
                                                         input logic [3:0] sc);
    logic [FE_CNT_W-1:0] p, h;
    case (pre)
      2'd0:    p = FE_CNT_W'(2);
      2'd1:    p = FE_CNT_W'(3);
      2'd2:    p = FE_CNT_W'(5);
      default: p = FE_CNT_W'(7);
    endcase
    if (sc < 4'd4) h = FE_CNT_W'(sc) + FE_CNT_W'(1);
    else           h = FE_CNT_W'(1) << (sc - 4'd1);
    return p * h;
  endfunction

  // delay in clocks: odd prescaler times 2^(sc+1)
  function automatic logic [FE_CNT_W-1:0] fe_delay(input logic [1:0] pre,
                                                   input logic [3:0] sc);
    logic [FE_CNT_W-1:0] p;
    p = FE_CNT_W'({pre, 1'b1});
    return p << ({1'b0, sc} + 5'd1);
  endfunction
endpackage

// File: rtl/spi_fe_cfg.sv
module spi_fe_cfg #(
  parameter int CNT_W = spi_fe_pkg::FE_CNT_W,
  parameter int WW    = 5
) (
  input  logic [31:0]      attr,
  output logic [WW-1:0]    width,
  output logic             cpol,
  output logic             cpha,
  output logic             lsb_first,
  output logic [CNT_W-1:0] half,
  output logic [CNT_W-1:0] lead,
  output logic [CNT_W-1:0] trail,
  output logic [CNT_W-1:0] gap
);
  import spi_fe_pkg::*;
  localparam int MIN_BITS = 4;

  logic [3:0] fsz;
  assign fsz       = attr[30:27];
  assign cpol      = attr[26];
  assign cpha      = attr[25];
  assign lsb_first = attr[24];

  always_comb begin
    if (fsz < 4'(MIN_BITS - 1)) width = WW'(MIN_BITS);
    else                        width = WW'(fsz) + WW'(1);
  end

  assign half  = CNT_W'(fe_half_period(attr[17:16], attr[3:0]));
  assign lead  = CNT_W'(fe_delay(attr[23:22], attr[15:12]));
  assign trail = CNT_W'(fe_delay(attr[21:20], attr[11:8]));
  assign gap   = CNT_W'(fe_delay(attr[19:18], attr[7:4]));
endmodule

// File: rtl/spi_fe_bits.sv
module spi_fe_bits #(
  parameter int DW = 16,
  parameter int WW = 5,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] tx_in,
  input  logic          lsb_first,
  input  logic [WW-1:0] width,
  input  logic          shift_en,
  input  logic [IW-1:0] shift_idx,
  input  logic          samp_en,
  input  logic [IW-1:0] samp_idx,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_acc
);
  logic [DW-1:0] tx_q;

  // wire-order index -> word bit position
  function automatic logic [IW-1:0] pos(input logic [IW-1:0] idx);
    logic [WW-1:0] t;
    t = width - WW'(1) - WW'(idx);
    return lsb_first ? idx : IW'(t);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_acc <= '0;
      mosi   <= 1'b0;
    end else if (load) begin
      tx_q   <= tx_in;
      rx_acc <= '0;
      mosi   <= tx_in[pos('0)];
    end else begin
      if (shift_en) mosi <= tx_q[pos(shift_idx)];
      if (samp_en)  rx_acc[pos(samp_idx)] <= miso;
    end
  end

  // R4
  shift_samp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && samp_en));
  // R4
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(shift_en || samp_en));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int DW    = 16,
  parameter int NCS   = 6,
  parameter int CNT_W = spi_fe_pkg::FE_CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    attr,
  input  logic           frm_valid,
  output logic           frm_ready,
  input  logic [DW-1:0]  frm_tx,
  input  logic [NCS-1:0] frm_cs,
  input  logic           frm_cont,
  input  logic           miso,
  output logic           sck,
  output logic           mosi,
  output logic [NCS-1:0] cs_n,
  output logic [DW-1:0]  rx_word,
  output logic           frm_done
);
  import spi_fe_pkg::*;
  localparam int WW = $clog2(DW + 1);
  localparam int IW = $clog2(DW);
  localparam int EW = $clog2(2 * DW + 1);

  fe_state_e        state;
  logic [31:0]      attr_q, attr_eff;
  logic [CNT_W-1:0] cnt, hcnt;
  logic [EW-1:0]    edge_n, e_new, last_e;
  logic             cont_q, accept, tick, samp_en, shift_en;
  logic [WW-1:0]    width;
  logic             cpol, cpha, lsb_first;
  logic [CNT_W-1:0] half, lead, trail, gap;
  logic [DW-1:0]    rx_acc;

  // live attribute while idle so acceptance sees the new frame's settings
  assign attr_eff  = (state == ST_IDLE) ? attr : attr_q;
  assign frm_ready = (state == ST_IDLE);
  assign accept    = frm_valid && frm_ready;

  spi_fe_cfg #(.CNT_W(CNT_W), .WW(WW)) u_cfg (
    .attr(attr_eff), .width(width), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .half(half), .lead(lead), .trail(trail), .gap(gap)
  );

  assign e_new    = edge_n + EW'(1);
  assign last_e   = EW'(width) << 1;
  assign tick     = (state == ST_XFER) && (hcnt == '0);
  assign samp_en  = tick && (e_new[0] ^ cpha);
  assign shift_en = tick && !(e_new[0] ^ cpha) && (e_new != last_e)
                    && !(cpha && (e_new == EW'(1)));

  spi_fe_bits #(.DW(DW), .WW(WW), .IW(IW)) u_bits (
    .clk(clk), .rst_n(rst_n), .load(accept), .tx_in(frm_tx),
    .lsb_first(lsb_first), .width(width),
    .shift_en(shift_en), .shift_idx(IW'(e_new >> 1)),
    .samp_en(samp_en), .samp_idx(IW'((e_new - EW'(1)) >> 1)),
    .miso(miso), .mosi(mosi), .rx_acc(rx_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      attr_q   <= '0;
      cont_q   <= 1'b0;
      cnt      <= '0;
      hcnt     <= '0;
      edge_n   <= '0;
      sck      <= 1'b0;
      cs_n     <= '1;
      rx_word  <= '0;
      frm_done <= 1'b0;
    end else begin
      frm_done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          attr_q <= attr;
          cont_q <= frm_cont;
          cs_n   <= ~frm_cs;
          sck    <= cpol;
          cnt    <= lead - CNT_W'(1);
          state  <= ST_LEAD;
        end
        ST_LEAD: if (cnt == '0) begin
          hcnt   <= half - CNT_W'(1);
          edge_n <= '0;
          state  <= ST_XFER;
        end else cnt <= cnt - CNT_W'(1);
        ST_XFER: if (tick) begin
          sck    <= ~sck;
          edge_n <= e_new;
          hcnt   <= half - CNT_W'(1);
          if (e_new == last_e) begin
            cnt   <= trail - CNT_W'(1);
            state <= ST_TRAIL;
          end
        end else hcnt <= hcnt - CNT_W'(1);
        ST_TRAIL: if (cnt == '0) begin
          frm_done <= 1'b1;
          rx_word  <= rx_acc;
          if (!cont_q) cs_n <= '1;
          cnt   <= gap - CNT_W'(1);
          state <= ST_GAP;
        end else cnt <= cnt - CNT_W'(1);
        ST_GAP: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LEAD || state == ST_TRAIL || state == ST_GAP) |-> (sck == cpol));
  // R3
  sck_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> ($past(state) == ST_XFER || $past(state) == ST_IDLE));
  // R6
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER) |-> (edge_n < last_e));
  // R7
  cs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER) |-> ($countones(~cs_n) >= 1));
  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !cont_q) |-> (cs_n == '1));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |-> $stable(rx_word));
  // R9
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(attr_q));
endmodule

// File: tb/sim_spi_frame_engine.sv
module sim_spi_frame_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NCS = 6;
  localparam int NFR = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] attr = '0;
  logic frm_valid = 1'b0, frm_cont = 1'b0, miso = 1'b0;
  logic [DW-1:0] frm_tx = '0;
  logic [NCS-1:0] frm_cs = '0;
  logic frm_ready, sck, mosi, frm_done;
  logic [NCS-1:0] cs_n;
  logic [DW-1:0] rx_word;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_frame_engine #(.DW(DW), .NCS(NCS)) u0 (
    .clk(clk), .rst_n(rst_n), .attr(attr), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_tx(frm_tx), .frm_cs(frm_cs),
    .frm_cont(frm_cont), .miso(miso), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .rx_word(rx_word), .frm_done(frm_done)
  );

  typedef struct {
    int fsz, cpol, cpha, lsb, pl, sl, pa, sa, pg, sg, pb, sb;
    int tx, sw, cs, cont;
  } frame_t;
  frame_t fr[NFR];

  function automatic int baud_pre(int c);
    case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction
  function automatic int baud_sc(int c);
    if (c < 4) return 2 * (c + 1);
    return 1 << c;
  endfunction
  function automatic int dly(int p, int s);
    return (2 * p + 1) * (2 << s);
  endfunction
  function automatic logic [31:0] mk_attr(frame_t f);
    return {1'b0, 4'(f.fsz), 1'(f.cpol), 1'(f.cpha), 1'(f.lsb), 2'(f.pl), 2'(f.pa),
            2'(f.pg), 2'(f.pb), 4'(f.sl), 4'(f.sa), 4'(f.sg), 4'(f.sb)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model state
  bit m_active = 0;
  int m_t = 0, m_L, m_H, m_A, m_G, m_W, m_cpol, m_cpha, m_lsb, m_tx, m_sw, m_cs, m_cont;
  int exp_rx = 0;
  int fi = 0;
  bit hs_next = 0;

  function automatic int posn(int n);
    return m_lsb ? n : m_W - 1 - n;
  endfunction
  function automatic int txbit(int n);
    return (m_tx >> posn(n)) & 1;
  endfunction

  task automatic load_model(frame_t f);
    m_active = 1; m_t = 0;
    m_W = (f.fsz < 3) ? 4 : f.fsz + 1;
    m_H = baud_pre(f.pb) * baud_sc(f.sb) / 2;
    m_L = dly(f.pl, f.sl); m_A = dly(f.pa, f.sa); m_G = dly(f.pg, f.sg);
    m_cpol = f.cpol; m_cpha = f.cpha; m_lsb = f.lsb;
    m_tx = f.tx; m_sw = f.sw; m_cs = f.cs; m_cont = f.cont;
  endtask

  // compare every port against the model for this cycle; drive miso
  task automatic model_step();
    int e_sck, e_mosi, e_cs, e_done, e_rdy, e, bi, xend, fend, m_miso;
    m_miso = 0;
    if (!m_active) begin
      e_sck = 0; e_mosi = 0; e_cs = 'h3F; e_done = 0; e_rdy = 1;
    end else begin
      xend = m_L + 2 * m_W * m_H;
      fend = xend + m_A;
      e_sck = m_cpol; e_done = 0; e_rdy = 0;
      e_cs = (~m_cs) & 'h3F;
      e_mosi = txbit(m_W - 1);
      if (m_t < m_L) e_mosi = txbit(0);
      else if (m_t < xend) begin
        e = (m_t - m_L) / m_H;
        e_sck = m_cpol ^ (e & 1);
        if (m_cpha) bi = (e == 0) ? 0 : (e - 1) >> 1;
        else        bi = e >> 1;
        if (bi > m_W - 1) bi = m_W - 1;
        e_mosi = txbit(bi);
        if ((e >> 1) < m_W) m_miso = (m_sw >> posn(e >> 1)) & 1;
      end else if (m_t >= fend) begin
        if (m_t == fend) begin
          e_done = 1;
          exp_rx = m_sw & ((1 << m_W) - 1);
        end
        if (!m_cont) e_cs = 'h3F;
        e_rdy = (m_t >= fend + m_G) ? 1 : 0;
      end
    end
    chk("R1 R2 R3 sck", int'(sck), e_sck);
    chk("R4 R6 mosi", int'(mosi), e_mosi);
    chk("R2 R7 cs_n", int'(cs_n), e_cs);
    chk("R2 R8 frm_done", int'(frm_done), e_done);
    chk("R5 R6 R8 rx_word", int'(rx_word), exp_rx);
    chk("R9 frm_ready", int'(frm_ready), e_rdy);
    miso = 1'(m_miso);
  endtask

  initial begin
    fr[0] = '{7, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 'h00A5, 'h003C, 'h01, 0};
    fr[1] = '{15, 1, 1, 1, 2, 0, 0, 0, 0, 0, 1, 1, 'h1234, 'hBEEF, 'h04, 1};
    fr[2] = '{3, 0, 1, 0, 0, 1, 3, 0, 1, 0, 2, 2, 'hFFF6, 'h123A, 'h20, 0};
    fr[3] = '{1, 1, 0, 1, 0, 0, 0, 1, 0, 0, 3, 0, 'hFF09, 'hFFFF, 'h02, 1};
    fr[4] = '{11, 1, 1, 0, 1, 0, 0, 0, 0, 2, 0, 4, 'h0ABC, 'h0F0F, 'h10, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 sck", int'(sck), 0);
    chk("R10 mosi", int'(mosi), 0);
    chk("R10 cs_n", int'(cs_n), 'h3F);
    chk("R10 rx_word", int'(rx_word), 0);
    chk("R10 frm_done", int'(frm_done), 0);
    chk("R10 frm_ready", int'(frm_ready), 1);
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (hs_next) begin
        load_model(fr[fi]);
        fi++;
        frm_valid = 1'b0;
      end else if (m_active) m_t++;
      model_step();
      if (!frm_valid) begin
        if (fi < NFR && cyc > 4) begin
          frm_valid = 1'b1;
          attr = mk_attr(fr[fi]);
          frm_tx = DW'(fr[fi].tx);
          frm_cs = NCS'(fr[fi].cs);
          frm_cont = 1'(fr[fi].cont);
        end else begin
          // R9: junk on the request fields while valid is low
          attr = 32'(cyc) * 32'h9E3779B9;
          frm_tx = DW'(cyc * 7919);
          frm_cs = NCS'(cyc);
          frm_cont = 1'(cyc);
        end
      end
      hs_next = frm_valid && frm_ready;
      if (fi == NFR && !frm_valid && frm_ready && m_t > 10000) break;
      if (fi == NFR && !frm_valid && frm_ready) m_t = (m_t < 10000) ? 20000 - 9990 + m_t : m_t;
    end
    if (fi != NFR) chk("R9 all frames accepted", fi, NFR);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule